// File: doc/BRIEF.md
# USB Host Root-Port Controller

This block tracks the life of a single full-speed/low-speed USB root port on the host side. It watches the single-ended receivers of the two data lines and notices when a device attaches or goes away. On attach it records the device speed from which line the device pulls up. It then moves the port through four states: detached, attached, enabled and suspended. Software steers the port with level and pulse commands that the current state gates. A bus-reset level drives SE0. A suspend pulse parks an enabled port. A resume level drives K toward a suspended device.

Each request to the line driver is a registered output. That covers the SE0 drive during reset, the K drive during resume, and a permit for the frame-start generator. The frame-start permit is held only while the port is enabled and not in reset. Two sticky flags report device loss and remote wakeup. Software clears each flag by writing one. A remote wakeup is a K state that a suspended device holds on the bus for a programmable number of clocks.

Top module: `uhp_port_ctrl`

## Requirements
- R1: Right after reset, port_state is 0 (detached) and low_speed, disc_flag, wake_irq, drv_se0, drv_resume and sof_run are all 0.
- R2: From detached, a non-SE0 line held for CONN_CYC cycles moves port_state to 1 (attached). At that moment low_speed captures dm_rx: 1 when DM is pulled up (low speed), 0 when DP is pulled up (full speed).
- R3: drv_se0 follows reset_req only while the port is attached or enabled. In the detached or suspended state, reset_req has no effect. While drv_se0 is high, port_state reads 1.
- R4: When reset_req falls during an active bus reset and the device is still present, port_state becomes 2 (enabled). sof_run is 1 exactly while port_state is 2.
- R5: A suspend_req pulse while enabled moves port_state to 3 (suspended) and drops sof_run. In any other state the pulse is ignored.
- R6: In the suspended state, resume_req drives drv_resume for as long as it is held. Its fall returns port_state to 2. Outside the suspended state, resume_req has no effect.
- R7: wake_irq is set when the bus shows K for at least wake_len consecutive cycles while the port is suspended and not resuming. A shorter K, or a K in any other state, leaves it clear. For a full-speed device K is dp=0, dm=1; for a low-speed device K is dp=1, dm=0.
- R8: A one-cycle wake_flag_clr pulse clears wake_irq.
- R9: SE0 held for DISC_CYC cycles while no bus reset is driven sends the port to 0 from any state, sets disc_flag, and drops drv_se0, drv_resume and sof_run. Shorter SE0, or SE0 seen during a driven reset, is ignored.
- R10: A one-cycle disc_flag_clr pulse clears disc_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_rx | input | 1 | DP single-ended receiver (asynchronous) |
| dm_rx | input | 1 | DM single-ended receiver (asynchronous) |
| reset_req | input | 1 | Bus reset command level |
| suspend_req | input | 1 | Suspend command pulse |
| resume_req | input | 1 | Resume command level |
| disc_flag_clr | input | 1 | Write-one clear of disc_flag |
| wake_flag_clr | input | 1 | Write-one clear of wake_irq |
| wake_len | input | WAKE_W | Minimum K length for remote wakeup, in cycles |
| port_state | output | 2 | 0 detached, 1 attached, 2 enabled, 3 suspended |
| low_speed | output | 1 | Speed captured at attach: 1 low, 0 full |
| disc_flag | output | 1 | Sticky device-loss flag |
| wake_irq | output | 1 | Sticky remote-wakeup flag and interrupt |
| drv_se0 | output | 1 | Request to drive SE0 (bus reset) |
| drv_resume | output | 1 | Request to drive K (resume) |
| sof_run | output | 1 | Permit for frame-start generation |

## Verification
The bench drives SE0 on the lines during a bus reset. A design that fails to mask disconnect detection while it drives reset would wrongly report device loss there. K pulses two cycles short of and two cycles past wake_len separate a correct threshold from one that fires early or never fires. K is also shown while the port is enabled. The bench tries each command in a state that must ignore it, which exposes any missing state gate. A low-speed attach follows a full-speed one, so a design that gets the K polarity wrong, or latches speed at the wrong moment, misses the wakeup or reports the wrong speed.

// File: rtl/uhp_pkg.sv
package uhp_pkg;
  typedef enum logic [1:0] {
    PS_DISC = 2'd0,
    PS_CONN = 2'd1,
    PS_EN   = 2'd2,
    PS_SUSP = 2'd3
  } port_st_e;
endpackage

// File: rtl/uhp_sync.sv
module uhp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stg[i-1].r;
      end
    end
  end
  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/uhp_line_mon.sv
module uhp_line_mon #(
  parameter int CONN_CYC = 8,
  parameter int DISC_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic dp_s,
  input  logic dm_s,
  input  logic mask_se0,
  output logic attached,
  output logic ls_dev,
  output logic k_seen
);
  localparam int MAXC  = (CONN_CYC > DISC_CYC) ? CONN_CYC : DISC_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CONN_LAST = CNT_W'(CONN_CYC - 1);
  localparam logic [CNT_W-1:0] DISC_LAST = CNT_W'(DISC_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             se0;

  assign se0 = !dp_s && !dm_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      attached <= 1'b0;
      ls_dev   <= 1'b0;
      cnt      <= '0;
    end else if (attached) begin
      if (se0 && !mask_se0) begin
        if (cnt == DISC_LAST) begin
          attached <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end else begin
      if (!se0) begin
        if (cnt == CONN_LAST) begin
          attached <= 1'b1;
          ls_dev   <= dm_s;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // K is the inverse of the device's idle level
  assign k_seen = ls_dev ? (dp_s && !dm_s) : (!dp_s && dm_s);
endmodule

// File: rtl/uhp_wake_det.sv
module uhp_wake_det #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              k_seen,
  input  logic [WAKE_W-1:0] wake_len,
  output logic              hit
);
  logic [WAKE_W-1:0] cnt;
  logic [WAKE_W-1:0] thr;

  assign thr = (wake_len == '0) ? WAKE_W'(1) : wake_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!arm || !k_seen) begin
      cnt <= '0;
    end else if (cnt < thr) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = arm && k_seen && (cnt == thr - 1'b1);
endmodule

// File: rtl/uhp_port_fsm.sv
module uhp_port_fsm
  import uhp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     attached,
  input  logic     wake_hit,
  input  logic     reset_req,
  input  logic     suspend_req,
  input  logic     resume_req,
  input  logic     disc_clr,
  input  logic     wake_clr,
  output port_st_e state,
  output logic     rst_on,
  output logic     res_on,
  output logic     sof_on,
  output logic     disc_flag,
  output logic     wake_flag
);
  port_st_e state_n;
  logic     rst_n_q, res_n_q, disc_set;

  always_comb begin
    state_n  = state;
    rst_n_q  = rst_on;
    res_n_q  = res_on;
    disc_set = 1'b0;
    if (state != PS_DISC && !attached) begin
      state_n  = PS_DISC;
      rst_n_q  = 1'b0;
      res_n_q  = 1'b0;
      disc_set = 1'b1;
    end else begin
      unique case (state)
        PS_DISC: if (attached) state_n = PS_CONN;
        PS_CONN: begin
          if (reset_req) rst_n_q = 1'b1;
          else if (rst_on) begin
            rst_n_q = 1'b0;
            state_n = PS_EN;
          end
        end
        PS_EN: begin
          if (reset_req) begin
            rst_n_q = 1'b1;
            state_n = PS_CONN;
          end else if (suspend_req) begin
            state_n = PS_SUSP;
          end
        end
        PS_SUSP: begin
          if (resume_req) res_n_q = 1'b1;
          else if (res_on) begin
            res_n_q = 1'b0;
            state_n = PS_EN;
          end
        end
        default: state_n = PS_DISC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_DISC;
      rst_on    <= 1'b0;
      res_on    <= 1'b0;
      sof_on    <= 1'b0;
      disc_flag <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      state  <= state_n;
      rst_on <= rst_n_q;
      res_on <= res_n_q;
      sof_on <= (state_n == PS_EN) && !rst_n_q;
      if (disc_set)      disc_flag <= 1'b1;
      else if (disc_clr) disc_flag <= 1'b0;
      if (wake_hit)      wake_flag <= 1'b1;
      else if (wake_clr) wake_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uhp_port_ctrl.sv
module uhp_port_ctrl
  import uhp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONN_CYC    = 8,
  parameter int DISC_CYC    = 8,
  parameter int WAKE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dp_rx,
  input  logic              dm_rx,
  input  logic              reset_req,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              disc_flag_clr,
  input  logic              wake_flag_clr,
  input  logic [WAKE_W-1:0] wake_len,
  output logic [1:0]        port_state,
  output logic              low_speed,
  output logic              disc_flag,
  output logic              wake_irq,
  output logic              drv_se0,
  output logic              drv_resume,
  output logic              sof_run
);
  logic [1:0] line_s;
  logic       attached, k_seen, wake_hit;
  port_st_e   st;

  uhp_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({dp_rx, dm_rx}), .q(line_s)
  );

  uhp_line_mon #(.CONN_CYC(CONN_CYC), .DISC_CYC(DISC_CYC)) u_mon (
    .clk(clk), .rst(rst), .dp_s(line_s[1]), .dm_s(line_s[0]),
    .mask_se0(drv_se0), .attached(attached), .ls_dev(low_speed),
    .k_seen(k_seen)
  );

  uhp_wake_det #(.WAKE_W(WAKE_W)) u_wake (
    .clk(clk), .rst(rst), .arm((st == PS_SUSP) && !drv_resume),
    .k_seen(k_seen), .wake_len(wake_len), .hit(wake_hit)
  );

  uhp_port_fsm u_fsm (
    .clk(clk), .rst(rst), .attached(attached), .wake_hit(wake_hit),
    .reset_req(reset_req), .suspend_req(suspend_req),
    .resume_req(resume_req), .disc_clr(disc_flag_clr),
    .wake_clr(wake_flag_clr), .state(st), .rst_on(drv_se0),
    .res_on(drv_resume), .sof_on(sof_run), .disc_flag(disc_flag),
    .wake_flag(wake_irq)
  );

  assign port_state = st;
endmodule

// File: rtl/uhp_port_ctrl_chk.sv
module uhp_port_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] port_state,
  input logic       disc_flag,
  input logic       wake_irq,
  input logic       drv_se0,
  input logic       drv_resume,
  input logic       sof_run
);
  assert_se0_gated_R3: assert property (@(posedge clk) disable iff (rst)
    drv_se0 |-> port_state == 2'd1);

  assert_sof_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    sof_run |-> port_state == 2'd2);

  assert_enable_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (port_state == 2'd2 && $past(port_state) != 2'd2) |->
      ($past(port_state) == 2'd1 || $past(port_state) == 2'd3));

  assert_suspend_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (port_state == 2'd3 && $past(port_state) != 2'd3) |->
      $past(port_state) == 2'd2);

  assert_resume_gated_R6: assert property (@(posedge clk) disable iff (rst)
    drv_resume |-> port_state == 2'd3);

  assert_wake_in_suspend_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> $past(port_state) == 2'd3);

  assert_disc_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(disc_flag) |-> port_state == 2'd0);
endmodule

bind uhp_port_ctrl uhp_port_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .port_state(port_state), .disc_flag(disc_flag),
  .wake_irq(wake_irq), .drv_se0(drv_se0), .drv_resume(drv_resume),
  .sof_run(sof_run)
);

// File: tb/uhp_port_ctrl_test.sv
module uhp_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dp_rx = 1'b0, dm_rx = 1'b0;
  logic       reset_req = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
  logic       disc_flag_clr = 1'b0, wake_flag_clr = 1'b0;
  logic [7:0] wake_len = 8'd10;
  logic [1:0] port_state;
  logic       low_speed, disc_flag, wake_irq, drv_se0, drv_resume, sof_run;

  int checks = 0, fails = 0, cycles = 0;
  logic done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] v;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  uhp_port_ctrl uut (
    .clk(clk), .rst(rst), .dp_rx(dp_rx), .dm_rx(dm_rx),
    .reset_req(reset_req), .suspend_req(suspend_req),
    .resume_req(resume_req), .disc_flag_clr(disc_flag_clr),
    .wake_flag_clr(wake_flag_clr), .wake_len(wake_len),
    .port_state(port_state), .low_speed(low_speed), .disc_flag(disc_flag),
    .wake_irq(wake_irq), .drv_se0(drv_se0), .drv_resume(drv_resume),
    .sof_run(sof_run)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      exp_t e;
      logic [7:0] act;
      wait (q.size() > 0);
      e = q.pop_front();
      act = {port_state, low_speed, disc_flag, wake_irq, drv_se0, drv_resume, sof_run};
      checks++;
      if (act !== e.v) begin
        fails++;
        $display("FAIL %s: actual %b expected %b (st ls df wk se0 res sof)", e.tag, act, e.v);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] st, input logic ls,
                            input logic df, input logic wk, input logic se0,
                            input logic res, input logic sof);
    exp_t e;
    e.tag = tag;
    e.v = {st, ls, df, wk, se0, res, sof};
    q.push_back(e);
    cyc(1);
  endtask

  task automatic line(input logic p, input logic m);
    dp_rx = p;
    dm_rx = m;
  endtask

  task automatic pulse_suspend();
    suspend_req = 1'b1; cyc(1); suspend_req = 1'b0; cyc(3);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    expect_out("R1 reset state", 2'd0, 0, 0, 0, 0, 0, 0);

    reset_req = 1'b1; cyc(6);
    expect_out("R3 reset ignored when detached", 2'd0, 0, 0, 0, 0, 0, 0);
    reset_req = 1'b0;

    line(1, 0); cyc(20);
    expect_out("R2 full-speed attach", 2'd1, 0, 0, 0, 0, 0, 0);

    pulse_suspend();
    expect_out("R5 suspend ignored when attached", 2'd1, 0, 0, 0, 0, 0, 0);

    reset_req = 1'b1; cyc(4);
    line(0, 0); cyc(20);
    expect_out("R3 reset drives SE0 / R9 SE0 masked", 2'd1, 0, 0, 0, 1, 0, 0);
    line(1, 0); cyc(6);
    reset_req = 1'b0; cyc(4);
    expect_out("R4 reset completion enables", 2'd2, 0, 0, 0, 0, 0, 1);

    resume_req = 1'b1; cyc(6);
    expect_out("R6 resume ignored when enabled", 2'd2, 0, 0, 0, 0, 0, 1);
    resume_req = 1'b0;

    line(0, 1); cyc(20); line(1, 0); cyc(6);
    expect_out("R7 K while enabled ignored", 2'd2, 0, 0, 0, 0, 0, 1);

    pulse_suspend();
    expect_out("R5 suspend from enabled", 2'd3, 0, 0, 0, 0, 0, 0);

    reset_req = 1'b1; cyc(6);
    expect_out("R3 reset ignored when suspended", 2'd3, 0, 0, 0, 0, 0, 0);
    reset_req = 1'b0;

    line(0, 1); cyc(8); line(1, 0); cyc(6);
    expect_out("R7 short K no wakeup", 2'd3, 0, 0, 0, 0, 0, 0);

    line(0, 1); cyc(12); line(1, 0); cyc(6);
    expect_out("R7 long K wakeup", 2'd3, 0, 0, 1, 0, 0, 0);

    wake_flag_clr = 1'b1; cyc(1); wake_flag_clr = 1'b0; cyc(2);
    expect_out("R8 wake flag cleared", 2'd3, 0, 0, 0, 0, 0, 0);

    resume_req = 1'b1; cyc(4);
    expect_out("R6 resume drives K", 2'd3, 0, 0, 0, 0, 1, 0);
    resume_req = 1'b0; cyc(3);
    expect_out("R6 resume end enables", 2'd2, 0, 0, 0, 0, 0, 1);

    line(0, 0); cyc(20);
    expect_out("R9 disconnect from enabled", 2'd0, 0, 1, 0, 0, 0, 0);

    disc_flag_clr = 1'b1; cyc(1); disc_flag_clr = 1'b0; cyc(2);
    expect_out("R10 disconnect flag cleared", 2'd0, 0, 0, 0, 0, 0, 0);

    line(0, 1); cyc(20);
    expect_out("R2 low-speed attach", 2'd1, 1, 0, 0, 0, 0, 0);
    reset_req = 1'b1; cyc(6); reset_req = 1'b0; cyc(4);
    expect_out("R4 low-speed enabled", 2'd2, 1, 0, 0, 0, 0, 1);
    pulse_suspend();
    line(1, 0); cyc(12); line(0, 1); cyc(6);
    expect_out("R7 low-speed K wakeup", 2'd3, 1, 0, 1, 0, 0, 0);

    line(0, 0); cyc(20);
    expect_out("R9 disconnect from suspended", 2'd0, 1, 1, 1, 0, 0, 0);
    disc_flag_clr = 1'b1; wake_flag_clr = 1'b1; cyc(1);
    disc_flag_clr = 1'b0; wake_flag_clr = 1'b0;

    line(1, 0); cyc(20);
    expect_out("R2 full-speed reattach", 2'd1, 0, 0, 0, 0, 0, 0);
    line(0, 0); cyc(4); line(1, 0); cyc(10);
    expect_out("R9 short SE0 ignored", 2'd1, 0, 0, 0, 0, 0, 0);

    cyc(2);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule